// File: doc/BRIEF.md
# I2C Repeated-START Generator

This block places a Repeated START condition on a pair of open-drain I2C lines. It works alongside the byte engine of a bus master. It paces each step with a reloadable down-counter, so one phase lasts `reload_val + 1` system clocks. At the points where another master could interfere, it watches the synchronized line levels. If it loses the bus, it lets go of both lines, sets a sticky collision flag and returns to idle. If it wins, it finishes with both lines held low and raises a one-cycle completion pulse. The byte engine then takes over the bus.

The block drives the bus only through two drive-low enables. Each line is assumed to read high unless this block or some other device pulls it low. A request is a single-cycle strobe taken while the block is idle. `reload_val` must stay stable for the whole sequence, because the block reads it again at each phase. The block has no data stream, so all of its pins are plain control and status signals.

Top module: `i2c_rstart_gen`

## Requirements
- R1: After reset both drive-low enables are 0, `done` is 0 and `coll_flag` is 0.
- R2: When a request is taken in idle, the block releases SDA and holds SCL low for `reload_val + 1` clocks, then releases SCL. With the request strobe sampled at edge e0, SCL is still driven low after edge e(R) and released after edge e(R+1).
- R3: Once the synchronized SCL reads high, the block samples the synchronized SDA. If SDA reads low, `coll_flag` sets, both lines are released and the block goes idle. With no clock stretching, the flag is seen after edge e(R+4).
- R4: If SDA reads high, a second phase of `reload_val + 1` clocks starts. If the synchronized SCL reads low during that phase, `coll_flag` sets and both lines are released. When SCL is pulled low after edge e(R+5), the flag is seen after edge e(R+8).
- R5: SDA pulled low by another device during the second phase is not a collision.
- R6: At the end of the second phase the block drives SDA low and starts a third phase. At the end of the third phase it drives SCL low, whatever level SCL has, and raises `done` for exactly one clock. With no stretching, `done` is seen after edge e(3R+6).
- R7: While SCL is held low by another device after release, the block waits. Each extra clock of hold delays every later step by one clock.
- R8: A `reload_val` of 0 gives one-clock phases, so a full sequence completes after edge e6.
- R9: `sda_in` and `scl_in` pass through two flip-flops before any decision. A change in a line is acted on at the third rising edge after it.
- R10: A request that arrives while a sequence is running is ignored. It does not change the timing and does not produce a second outcome.
- R11: `coll_flag` stays set until `clr_coll` is pulsed. When a new collision and `clr_coll` fall in the same clock, the flag stays set.
- R12: After completion, both lines stay driven low until the next request. After a collision, both stay released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Single-cycle request to begin a Repeated START |
| reload_val | input | 7 | Phase length minus one, in clocks |
| sda_in | input | 1 | Level read from the SDA line |
| scl_in | input | 1 | Level read from the SCL line |
| clr_coll | input | 1 | Pulse to clear the collision flag |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| done | output | 1 | One-clock pulse on a successful finish |
| coll_flag | output | 1 | Sticky bus-collision flag |

## Verification
The collision detector and the software clear can act on the flag in the same clock. The bench holds SDA low through a sequence so that the SDA sample fails at a known edge, and it pulses `clr_coll` across exactly that edge. It judges the result by the flag still reading 1 afterwards and by the scoreboard seeing the flag rise at the predicted cycle. The bench also models the wired-AND bus so that other-master activity, such as an SDA fall or an SCL pull-down in the second and third phases, lands on exactly computed edges.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_SCL_REL = 3'd2,
    ST_HOLD    = 3'd3,
    ST_SDA_LOW = 3'd4
  } rs_state_e;
endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] RST_VEC = {W{RST_VAL}};

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VEC;
        else        stg[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VEC;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rs_baud_cnt.sv
module rs_baud_cnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] reload,
  output logic         tick
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= reload;
    else if (cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end

  assign tick = (cnt_q == '0);
endmodule

// File: rtl/rs_coll_flag.sv
module rs_coll_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/rs_seq_fsm.sv
module rs_seq_fsm
  import rs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic sda_s,
  input  logic scl_s,
  input  logic tick,
  output logic cnt_load,
  output logic sda_low,
  output logic scl_low,
  output logic done,
  output logic coll_set
);
  rs_state_e state_q, state_d;
  logic      sda_d, scl_d, done_d;

  always_comb begin
    state_d  = state_q;
    sda_d    = sda_low;
    scl_d    = scl_low;
    done_d   = 1'b0;
    cnt_load = 1'b0;
    coll_set = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          sda_d    = 1'b0;
          scl_d    = 1'b1;
          cnt_load = 1'b1;
          state_d  = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (tick) begin
          scl_d   = 1'b0;
          state_d = ST_SCL_REL;
        end
      end
      ST_SCL_REL: begin
        if (scl_s) begin
          if (!sda_s) begin
            coll_set = 1'b1;
            sda_d    = 1'b0;
            scl_d    = 1'b0;
            state_d  = ST_IDLE;
          end else begin
            cnt_load = 1'b1;
            state_d  = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (!scl_s) begin
          coll_set = 1'b1;
          sda_d    = 1'b0;
          scl_d    = 1'b0;
          state_d  = ST_IDLE;
        end else if (tick) begin
          sda_d    = 1'b1;
          cnt_load = 1'b1;
          state_d  = ST_SDA_LOW;
        end
      end
      ST_SDA_LOW: begin
        if (tick) begin
          scl_d   = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sda_low <= 1'b0;
      scl_low <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      sda_low <= sda_d;
      scl_low <= scl_d;
      done    <= done_d;
    end
  end
endmodule

// File: rtl/i2c_rstart_gen.sv
module i2c_rstart_gen #(
  parameter int RELOAD_W    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  logic [RELOAD_W-1:0] reload_val,
  input  logic                sda_in,
  input  logic                scl_in,
  input  logic                clr_coll,
  output logic                sda_drive_low,
  output logic                scl_drive_low,
  output logic                done,
  output logic                coll_flag
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_raw, line_s;
  logic             tick, cnt_load, coll_set;

  assign line_raw = {scl_in, sda_in};

  rs_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (line_raw),
    .q    (line_s)
  );

  rs_baud_cnt #(.W(RELOAD_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cnt_load),
    .reload(reload_val),
    .tick  (tick)
  );

  rs_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_req(start_req),
    .sda_s    (line_s[0]),
    .scl_s    (line_s[1]),
    .tick     (tick),
    .cnt_load (cnt_load),
    .sda_low  (sda_drive_low),
    .scl_low  (scl_drive_low),
    .done     (done),
    .coll_set (coll_set)
  );

  rs_coll_flag u_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (coll_set),
    .clr  (clr_coll),
    .flag (coll_flag)
  );
endmodule

// File: rtl/i2c_rstart_chk.sv
module i2c_rstart_chk (
  input logic clk,
  input logic rst_n,
  input logic clr_coll,
  input logic sda_drive_low,
  input logic scl_drive_low,
  input logic done,
  input logic coll_flag
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                   // R6
  AST_DONE_HOLDS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sda_drive_low && scl_drive_low));                        // R12
  AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_flag && !clr_coll) |=> coll_flag);                           // R11
  AST_COLL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_flag) |-> (!sda_drive_low && !scl_drive_low));          // R3
  AST_DONE_NOT_COLL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !$rose(coll_flag));                                       // R4
  AST_SDA_LOW_WITH_SCL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_drive_low);                          // R6
  AST_SDA_FREE_WITH_SCL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_low) |-> scl_drive_low);                           // R2
endmodule

bind i2c_rstart_gen i2c_rstart_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clr_coll     (clr_coll),
  .sda_drive_low(sda_drive_low),
  .scl_drive_low(scl_drive_low),
  .done         (done),
  .coll_flag    (coll_flag)
);

// File: tb/tb_i2c_rstart_gen.sv
`timescale 1ns/1ps
module tb_i2c_rstart_gen;
  typedef struct {
    bit    is_coll;
    int    at_cyc;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_req = 1'b0;
  logic [6:0] reload_val = '0;
  logic       clr_coll = 1'b0;
  logic       ext_sda_low = 1'b0;
  logic       ext_scl_low = 1'b0;
  logic       sda_in, scl_in;
  logic       sda_drive_low, scl_drive_low, done, coll_flag;

  int   cyc = 0;
  int   c0 = 0;
  int   checks = 0;
  int   failures = 0;
  int   pushed = 0;
  int   seen = 0;
  bit   finished = 1'b0;
  bit   coll_prev = 1'b0;
  exp_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sda_in = ~(sda_drive_low | ext_sda_low);
  assign scl_in = ~(scl_drive_low | ext_scl_low);

  i2c_rstart_gen dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .reload_val   (reload_val),
    .sda_in       (sda_in),
    .scl_in       (scl_in),
    .clr_coll     (clr_coll),
    .sda_drive_low(sda_drive_low),
    .scl_drive_low(scl_drive_low),
    .done         (done),
    .coll_flag    (coll_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input int r, input bit is_coll, input int lat, input string tag);
    exp_t e;
    @(negedge clk);
    reload_val = 7'(r);
    start_req  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_req = 1'b0;
    c0 = cyc;
    e.is_coll = is_coll;
    e.at_cyc  = c0 + lat;
    e.tag     = tag;
    exp_q.push_back(e);
    pushed++;
  endtask

  task automatic wait_empty();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clr_coll = 1'b1;
    @(negedge clk);
    clr_coll = 1'b0;
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      bit ev_done, ev_coll;
      ev_done = done;
      ev_coll = coll_flag && !coll_prev;
      coll_prev = coll_flag;
      if (ev_done || ev_coll) begin
        seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected outcome", int'(ev_coll), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(ev_coll == e.is_coll && ev_done == !e.is_coll,
                {e.tag, " outcome kind"}, int'(ev_coll), int'(e.is_coll));
          check(cyc == e.at_cyc, {e.tag, " outcome cycle"}, cyc - c0, e.at_cyc - c0);
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(sda_drive_low == 1'b0, "R1 sda release in reset", sda_drive_low, 0);
    check(scl_drive_low == 1'b0, "R1 scl release in reset", scl_drive_low, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done idle", done, 0);
    check(coll_flag == 1'b0, "R1 flag clear", coll_flag, 0);

    // R2 R6 R9: normal sequence, R=5, latency 3R+6
    run_seq(5, 1'b0, 21, "R6 normal r5");
    repeat (5) @(negedge clk);
    check(scl_drive_low == 1'b1, "R2 scl held through phase", scl_drive_low, 1);
    check(sda_drive_low == 1'b0, "R2 sda released", sda_drive_low, 0);
    @(negedge clk);
    check(scl_drive_low == 1'b0, "R2 scl released after phase", scl_drive_low, 0);
    wait_empty();
    check(sda_drive_low && scl_drive_low, "R12 lines held after done",
          int'({sda_drive_low, scl_drive_low}), 3);

    // R8: zero reload
    run_seq(0, 1'b0, 6, "R8 zero reload");
    wait_empty();

    // R3: SDA held low by other master, R=3, latency R+4
    ext_sda_low = 1'b1;
    run_seq(3, 1'b1, 7, "R3 sda low at scl rise");
    wait_empty();
    check(!sda_drive_low && !scl_drive_low, "R12 lines free after abort",
          int'({sda_drive_low, scl_drive_low}), 0);
    ext_sda_low = 1'b0;
    repeat (10) @(negedge clk);
    check(coll_flag == 1'b1, "R11 flag sticky", coll_flag, 1);
    pulse_clear();
    check(coll_flag == 1'b0, "R11 flag cleared", coll_flag, 0);

    // R4 R9: SCL pulled low during second phase, R=4, pull after e(R+5), latency R+8
    run_seq(4, 1'b1, 12, "R4 scl low in hold");
    repeat (9) @(negedge clk);
    ext_scl_low = 1'b1;
    wait_empty();
    check(!sda_drive_low && !scl_drive_low, "R4 lines released",
          int'({sda_drive_low, scl_drive_low}), 0);
    ext_scl_low = 1'b0;
    pulse_clear();

    // R5: SDA falls during second phase, R=6, pull after e(R+6)
    run_seq(6, 1'b0, 24, "R5 foreign sda fall");
    repeat (12) @(negedge clk);
    ext_sda_low = 1'b1;
    wait_empty();
    ext_sda_low = 1'b0;
    check(coll_flag == 1'b0, "R5 no collision", coll_flag, 0);

    // R7: clock stretch, R=2, held until after e8, latency 3R+6+5
    ext_scl_low = 1'b1;
    run_seq(2, 1'b0, 17, "R7 scl stretch");
    repeat (8) @(negedge clk);
    ext_scl_low = 1'b0;
    wait_empty();

    // R10: second request during the sequence is ignored, R=4
    run_seq(4, 1'b0, 18, "R10 busy request");
    @(negedge clk);
    @(negedge clk);
    reload_val = 7'd0;
    start_req  = 1'b1;
    @(negedge clk);
    start_req  = 1'b0;
    reload_val = 7'd4;
    wait_empty();
    repeat (30) @(negedge clk);
    check(seen == pushed, "R10 outcome count", seen, pushed);

    // R6: SCL pulled low in third phase is ignored, R=3, pull after e(2R+5)
    run_seq(3, 1'b0, 15, "R6 scl low in last phase");
    repeat (11) @(negedge clk);
    ext_scl_low = 1'b1;
    wait_empty();
    ext_scl_low = 1'b0;
    check(coll_flag == 1'b0, "R6 no collision in last phase", coll_flag, 0);

    // R11: clear and new collision in the same clock, R=3, collision at e7
    ext_sda_low = 1'b1;
    run_seq(3, 1'b1, 7, "R11 set over clear");
    repeat (6) @(negedge clk);
    clr_coll = 1'b1;
    @(negedge clk);
    clr_coll = 1'b0;
    @(negedge clk);
    check(coll_flag == 1'b1, "R11 set wins over clear", coll_flag, 1);
    wait_empty();
    ext_sda_low = 1'b0;
    pulse_clear();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule